// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a test-port data register that lets an external debugger reach a small bank of on-chip debug registers. The TAP controller drives it with capture, shift and update strobes in the test clock domain, plus the serial input. The block returns serial output. Each scan moves a 38-bit frame that holds a data word, a register address and a direction flag.

Writes take effect at the update step of the scan that carries them. Reads are pipelined. A read scan only latches its address. The value of that register is loaded into the frame at the next capture and comes out during the next scan.

Capturing the comms data word consumes it and clears its pending flag. For this reason a debugger finishes a read sequence by leaving the comms control address in the chain. A capture of comms control has no side effect.

Top module: `dbgsc_top`

## Requirements
- R1: A frame is 38 bits and is shifted least significant bit first. Bits 31:0 hold data, bits 36:32 hold the register address, and bit 37 is the direction (1 = write, 0 = read). TDI is sampled on the rising edge of tck. TDO is updated on the falling edge from the frame's bit 0.
- R2: At update, a write frame stores its data into the addressed register, cut to that register's width. The widths are: debug control (0) 6 bits, vector catch (2) 8 bits, comms data (5) 32 bits. Each watch unit (unit 0 at 8..13, unit 1 at 16..21) holds address value 32, address mask 32, data value 32, data mask 32, control value 9 and control mask 8 bits. Bits above a register's width read as zero.
- R3: At update, a read frame latches its address. The next capture loads that register's value into bits 31:0. A write frame leaves the latched read address unchanged.
- R4: On reset, the latched read address becomes 0. Every writable register becomes zero, except debug control, which resets to 0x10 (bit 4, monitor enable, set). Software can clear that bit.
- R5: Addresses 3, 6, 7, 14, 15 and 22..31 read as zero, and writes to them change no register.
- R6: Address 1 (debug status) returns the 5-bit status input in bits 4:0. Writes to it are ignored.
- R7: Address 4 (comms control) is read-only. Bits 31:28 hold the VERSION parameter (default 6), bit 0 is the pending flag, and all other bits are zero.
- R8: A write to comms data sets the pending flag. A capture of comms data clears it. A capture of comms control leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge, TDO on its falling edge |
| rst | input | 1 | Synchronous active-high test reset |
| capture_dr | input | 1 | Capture strobe: load the frame from the latched read address |
| shift_dr | input | 1 | Shift strobe: move the frame one bit toward TDO |
| update_dr | input | 1 | Update strobe: perform the write or latch the read address |
| tdi | input | 1 | Serial data in |
| status_i | input | 5 | Core status bits returned at the debug status address |
| tdo | output | 1 | Serial data out |

## Verification
The bench sends three kinds of input pattern.

- All-ones writes expose the width cut of each register and show that unmapped and read-only addresses ignore writes.
- Chains of back-to-back reads with distinct addresses test the one-scan pipeline. A wrong latch point would return data from the wrong register.
- Writes placed between reads show that a write does not disturb the pending read address.

A comms sequence tells the two captures apart. In it, comms control is read twice after a data write, then the data is read, then control is read again. This shows that only a capture of comms data clears the pending flag. A second reset in the middle of the run confirms the reset values again.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 5;
    localparam int FRAME_W      = DATA_W + ADDR_W + 1;

    localparam int CTRL_W       = 6;
    localparam int STAT_W       = 5;
    localparam int VCATCH_W     = 8;
    localparam int VER_W        = 4;
    localparam int WCV_W        = 9;
    localparam int WCM_W        = 8;

    localparam int NUM_WATCH    = 2;
    localparam int WATCH_FIELDS = 6;
    localparam int WATCH_BASE   = 8;
    localparam int WATCH_STRIDE = 8;
    localparam int WSEL_W       = 3;

    localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(6'h10);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 5'd0,
        RA_STATUS = 5'd1,
        RA_VCATCH = 5'd2,
        RA_CCTRL  = 5'd4,
        RA_CDATA  = 5'd5
    } reg_addr_e;

    typedef enum logic [WSEL_W-1:0] {
        WF_ADDR_VAL = 3'd0,
        WF_ADDR_MSK = 3'd1,
        WF_DATA_VAL = 3'd2,
        WF_DATA_MSK = 3'd3,
        WF_CTRL_VAL = 3'd4,
        WF_CTRL_MSK = 3'd5
    } watch_field_e;

    function automatic logic [DATA_W-1:0] low_mask(input int width);
        if (width >= DATA_W) return '1;
        return (DATA_W'(1) << width) - DATA_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] watch_field_mask(input int idx);
        case (idx)
            4:       return low_mask(WCV_W);
            5:       return low_mask(WCM_W);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/dbgsc_shift.sv
module dbgsc_shift
    import dbgsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  logic   shift,
    input  logic   tdi,
    input  frame_t cap_frame,
    output frame_t frame_q,
    output logic   tdo
);

    frame_t sr_q;
    logic   tdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (capture) begin
            sr_q <= cap_frame;
        end else if (shift) begin
            sr_q <= frame_t'({tdi, sr_q[FRAME_W-1:1]});
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            tdo_q <= 1'b0;
        end else begin
            tdo_q <= sr_q[0];
        end
    end

    assign frame_q = sr_q;
    assign tdo     = tdo_q;

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        shift && !capture |=> sr_q.wr == $past(tdi)); // R1

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift && !capture |=> $stable(sr_q)); // R1

endmodule

// File: rtl/dbgsc_watch_unit.sv
module dbgsc_watch_unit
    import dbgsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] field_q [WATCH_FIELDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WATCH_FIELDS; i++) begin
            if (rst) begin
                field_q[i] <= '0;
            end else if (wr_en && wr_sel == WSEL_W'(i)) begin
                field_q[i] <= wdata & watch_field_mask(i);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < WATCH_FIELDS; i++) begin
            if (rd_sel == WSEL_W'(i)) rdata = field_q[i];
        end
    end

    AST_WU_CV_NARROW: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == WF_CTRL_VAL |=> field_q[4][DATA_W-1:WCV_W] == '0); // R2

    AST_WU_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(field_q[0]) && $stable(field_q[5])); // R5

endmodule

// File: rtl/dbgsc_regbank.sv
module dbgsc_regbank
    import dbgsc_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [STAT_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata
);

    localparam int CC_PAD_W = DATA_W - VER_W - 1;

    logic [CTRL_W-1:0]   ctrl_q;
    logic [VCATCH_W-1:0] vcatch_q;
    logic [DATA_W-1:0]   cdata_q;
    logic                pend_q;

    logic [NUM_WATCH-1:0] wu_wr_hit;
    logic [NUM_WATCH-1:0] wu_rd_hit;
    logic [DATA_W-1:0]    wu_rdata [NUM_WATCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            vcatch_q <= '0;
            cdata_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CTRL:   ctrl_q   <= wdata[CTRL_W-1:0];
                RA_VCATCH: vcatch_q <= wdata[VCATCH_W-1:0];
                RA_CDATA:  cdata_q  <= wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (wr_en && wr_addr == RA_CDATA) begin
            pend_q <= 1'b1;
        end else if (cap && rd_addr == RA_CDATA) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar u = 0; u < NUM_WATCH; u++) begin : g_watch
        localparam int BASE = WATCH_BASE + u * WATCH_STRIDE;

        assign wu_wr_hit[u] = (wr_addr >= ADDR_W'(BASE)) &&
                              (wr_addr <  ADDR_W'(BASE + WATCH_FIELDS));
        assign wu_rd_hit[u] = (rd_addr >= ADDR_W'(BASE)) &&
                              (rd_addr <  ADDR_W'(BASE + WATCH_FIELDS));

        dbgsc_watch_unit u_watch (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en && wu_wr_hit[u]),
            .wr_sel (wr_addr[WSEL_W-1:0]),
            .wdata  (wdata),
            .rd_sel (rd_addr[WSEL_W-1:0]),
            .rdata  (wu_rdata[u])
        );
    end

    always_comb begin
        rdata = '0;
        case (rd_addr)
            RA_CTRL:   rdata = DATA_W'(ctrl_q);
            RA_STATUS: rdata = DATA_W'(status_i);
            RA_VCATCH: rdata = DATA_W'(vcatch_q);
            RA_CCTRL:  rdata = {VERSION, {CC_PAD_W{1'b0}}, pend_q};
            RA_CDATA:  rdata = cdata_q;
            default: begin
                for (int u = 0; u < NUM_WATCH; u++) begin
                    if (wu_rd_hit[u]) rdata = wu_rdata[u];
                end
            end
        endcase
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == RA_CDATA |=> pend_q); // R8

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cap && rd_addr == RA_CDATA && !wr_en |=> !pend_q); // R8

    AST_PEND_CCTRL_CAP: assert property (@(posedge clk) disable iff (rst)
        cap && rd_addr == RA_CCTRL && !wr_en |=> $stable(pend_q)); // R8

    AST_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == RA_CCTRL || wr_addr == RA_STATUS) |=>
        $stable(pend_q) && $stable(ctrl_q) && $stable(cdata_q)); // R7

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr > ADDR_W'(WATCH_BASE + (NUM_WATCH - 1) * WATCH_STRIDE + WATCH_FIELDS - 1) |=>
        $stable(ctrl_q) && $stable(vcatch_q) && $stable(cdata_q) && $stable(pend_q)); // R5

endmodule

// File: rtl/dbgsc_top.sv
module dbgsc_top
    import dbgsc_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 4'h6
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    input  logic [STAT_W-1:0] status_i,
    output logic              tdo
);

    frame_t            frame_q;
    frame_t            cap_frame;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rdata;
    logic              wr_en;

    assign wr_en = update_dr && frame_q.wr;

    always_ff @(posedge tck) begin
        if (rst) begin
            rd_addr_q <= '0;
        end else if (update_dr && !frame_q.wr) begin
            rd_addr_q <= frame_q.addr;
        end
    end

    always_comb begin
        cap_frame.wr   = 1'b0;
        cap_frame.addr = rd_addr_q;
        cap_frame.data = rdata;
    end

    dbgsc_shift u_shift (
        .clk       (tck),
        .rst       (rst),
        .capture   (capture_dr),
        .shift     (shift_dr),
        .tdi       (tdi),
        .cap_frame (cap_frame),
        .frame_q   (frame_q),
        .tdo       (tdo)
    );

    dbgsc_regbank #(
        .VERSION (VERSION)
    ) u_regs (
        .clk      (tck),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (frame_q.addr),
        .wdata    (frame_q.data),
        .cap      (capture_dr),
        .rd_addr  (rd_addr_q),
        .status_i (status_i),
        .rdata    (rdata)
    );

    AST_ONE_STROBE: assert property (@(posedge tck) disable iff (rst)
        $onehot0({capture_dr, shift_dr, update_dr})); // R1

    AST_RDADDR_WRITE_HOLD: assert property (@(posedge tck) disable iff (rst)
        update_dr && frame_q.wr |=> $stable(rd_addr_q)); // R3

    AST_RDADDR_READ_LATCH: assert property (@(posedge tck) disable iff (rst)
        update_dr && !frame_q.wr |=> rd_addr_q == $past(frame_q.addr)); // R3

endmodule

// File: tb/dbgsc_top_tb.sv
module dbgsc_top_tb;
    import dbgsc_pkg::*;

    logic              tck = 1'b0;
    logic              rst = 1'b1;
    logic              capture_dr = 1'b0;
    logic              shift_dr = 1'b0;
    logic              update_dr = 1'b0;
    logic              tdi = 1'b0;
    logic [STAT_W-1:0] status_i = '0;
    logic              tdo;

    always #5 tck = ~tck;

    dbgsc_top u_dut (
        .tck        (tck),
        .rst        (rst),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .status_i   (status_i),
        .tdo        (tdo)
    );

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    logic [31:0] obs;
    event        obs_ev;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    localparam logic [31:0] CC_BASE = 32'h6000_0000; // R7: version 6 in bits 31:28

    // monitor: pops expected items and compares with what came out of TDO
    initial begin
        forever begin
            item_t it;
            @(obs_ev);
            it = sbq.pop_front();
            if (it.chk) begin
                n_vec++;
                if (obs !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, obs, it.exp);
                end
            end
        end
    end

    // driver: one full capture/shift/update sequence, LSB first (R1)
    task automatic scan(input bit wr, input int addr, input logic [31:0] data,
                        input bit chk, input logic [31:0] exp, input string tag);
        logic [FRAME_W-1:0] f;
        logic [FRAME_W-1:0] got;
        item_t it;
        f = {wr, ADDR_W'(addr), data};
        it.chk = chk;
        it.exp = exp;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge tck); #1;
        capture_dr = 1'b1;
        for (int i = 0; i < FRAME_W; i++) begin
            @(negedge tck); #1;
            capture_dr = 1'b0;
            got[i]     = tdo;
            shift_dr   = 1'b1;
            tdi        = f[i];
        end
        @(negedge tck); #1;
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge tck); #1;
        update_dr = 1'b0;
        obs = got[31:0];
        ->obs_ev;
        #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge tck);
        #1 rst = 1'b0;

        // reset values, pipelined reads
        scan(0, 2,  '0, 1, 32'h10,    "R4 R1 debug control reset 0x10");
        scan(0, 4,  '0, 1, 32'h0,     "R4 vector catch reset");
        scan(0, 5,  '0, 1, CC_BASE,   "R7 comms control reset");
        scan(0, 8,  '0, 1, 32'h0,     "R4 comms data reset");

        // writes between reads do not move the read address
        scan(1, 0,  32'hFFFF_FFFF, 1, 32'h0, "R4 watch0 address value reset");
        scan(1, 2,  32'h1234_ABCD, 1, 32'h0, "R3 write keeps read address");
        scan(0, 0,  '0, 1, 32'h0,     "R3 read address still 8");
        scan(0, 2,  '0, 1, 32'h3F,    "R2 debug control cut to 6 bits");
        scan(1, 12, 32'hFFFF_FFFF, 1, 32'hCD, "R2 vector catch cut to 8 bits");
        scan(1, 13, 32'hFFFF_FF5A, 1, 32'hCD, "R3 read address held across write");
        scan(1, 8,  32'hDEAD_BEEF, 0, '0, "");
        scan(1, 19, 32'h1234_5678, 0, '0, "");
        status_i = 5'h15;
        scan(1, 3,  32'hFFFF_FFFF, 0, '0, "");
        scan(1, 31, 32'hFFFF_FFFF, 0, '0, "");
        scan(1, 1,  32'hFFFF_FFFF, 0, '0, "");
        scan(1, 4,  32'hFFFF_FFFF, 0, '0, "");

        // read chain across the map
        scan(0, 12, '0, 1, 32'hCD,        "R3 chain start");
        scan(0, 13, '0, 1, 32'h1FF,       "R2 watch0 control value 9 bits");
        scan(0, 8,  '0, 1, 32'h5A,        "R2 watch0 control mask 8 bits");
        scan(0, 19, '0, 1, 32'hDEAD_BEEF, "R2 watch0 address value");
        scan(0, 3,  '0, 1, 32'h1234_5678, "R2 watch1 data mask");
        scan(0, 31, '0, 1, 32'h0,         "R5 address 3 reads zero");
        scan(0, 1,  '0, 1, 32'h0,         "R5 address 31 reads zero");
        scan(0, 4,  '0, 1, 32'h15,        "R6 status input returned");
        scan(0, 0,  '0, 1, CC_BASE,       "R7 comms control ignores write");
        scan(0, 0,  '0, 1, 32'h3F,        "R5 unmapped writes left control alone");
        scan(1, 0,  32'h0000_000F, 1, 32'h3F, "R3 capture before monitor clear");
        scan(0, 4,  '0, 1, 32'h0F,        "R4 monitor enable bit cleared");

        // comms mailbox side effects
        scan(1, 5,  32'hCAFE_F00D, 1, CC_BASE,         "R8 pending clear before write");
        scan(0, 4,  '0, 1, CC_BASE | 32'h1,            "R8 write sets pending");
        scan(0, 5,  '0, 1, CC_BASE | 32'h1,            "R8 control capture keeps pending");
        scan(0, 4,  '0, 1, 32'hCAFE_F00D,              "R8 comms data read");
        scan(0, 4,  '0, 1, CC_BASE,                    "R8 data capture cleared pending");

        // second reset
        @(negedge tck); #1 rst = 1'b1;
        repeat (2) @(negedge tck);
        #1 rst = 1'b0;
        scan(0, 2,  '0, 1, 32'h10, "R4 control back to 0x10 after reset");
        scan(0, 0,  '0, 1, 32'h0,  "R4 vector catch zero after reset");

        repeat (2) @(negedge tck);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule